// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs an external 14-bit sampling analog-to-digital converter from a single system clock. It raises a start-convert pulse, then follows the converter's end-of-conversion handshake through a two-flop synchroniser. After the handshake has fallen and a programmable settling delay has passed, it latches the parallel result and marks it with a one-cycle valid strobe. All timing is set by parameters counted in clock cycles. At elaboration the block forces the pulse width and sample period into the converter's legal ranges. A high time that lands in the forbidden falling-edge interval is replaced by the shortest legal width.

Two request sources exist. In continuous mode a free-running pacer asks for a conversion once per sample period, which suits warm-up and calibration. In single-shot mode each request cycle asks for one conversion. The sequencer never starts the converter while a conversion is still in progress. A request that cannot be served is dropped and recorded in a sticky overrun flag. A missing or stuck handshake is caught by two timeouts, which set a sticky error flag. Both flags are cleared by one clear input.

Top module: `conv_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, start_conv, sample_valid, overrun and timeout_err are 0 and sample_data is all zeros.
- R2: Each start_conv pulse stays high for exactly START_HIGH clock cycles (default 2). Its rising edge begins a conversion.
- R3: With mode_cont=1 and run_en=1, successive start_conv rising edges are exactly SAMPLE_PERIOD cycles apart (default 34) whenever each conversion finishes within one period.
- R4: With mode_cont=0, run_en has no effect, and each single_req cycle that finds the sequencer idle produces exactly one start pulse.
- R5: No start pulse is issued while the synchronised end-of-conversion is high. A request that arrives then is dropped and sets overrun.
- R6: A request that arrives during a sequence (from start pulse through capture) is dropped, sets overrun, and does not disturb the sample being captured.
- R7: Each completed conversion gives one sample_valid pulse lasting one cycle. sample_data then holds the 14-bit offset-binary word (bit 13 is the MSB) that adc_data showed after eoc_in fell, passed through unaltered.
- R8: sample_valid rises on the (CAPTURE_DELAY+4)-th rising clock edge after eoc_in falls (default 6th).
- R9: If eoc_in has not been seen high within RISE_TIMEOUT cycles (default 8) after the start pulse ends, timeout_err is set, no sample is produced, and the next request is served normally.
- R10: If eoc_in stays high for more than FALL_TIMEOUT cycles (default 48), timeout_err is set and no sample is produced, even when eoc_in later falls.
- R11: overrun and timeout_err stay set until a cycle with flag_clr=1 clears them. If a set and a clear fall in the same cycle, the flag ends up set.
- R12: In continuous mode, a conversion longer than the sample period causes the period request that falls inside it to be dropped with overrun set. The conversion still delivers its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cont | input | 1 | 1 = free-running conversions, 0 = single-shot |
| run_en | input | 1 | Enables the free-running pacer (continuous mode only) |
| single_req | input | 1 | One-cycle conversion request in single-shot mode |
| flag_clr | input | 1 | Clears overrun and timeout_err |
| eoc_in | input | 1 | Asynchronous end-of-conversion from the converter, high while busy |
| adc_data | input | 14 | Parallel result from the converter, offset binary |
| start_conv | output | 1 | Start-convert pulse to the converter |
| sample_data | output | 14 | Last captured result |
| sample_valid | output | 1 | One-cycle strobe marking a new sample_data |
| overrun | output | 1 | Sticky: a request was dropped because a conversion was busy |
| timeout_err | output | 1 | Sticky: the handshake did not rise or fall in time |

## Verification
The overrun flag has two drivers that can act in the same cycle: a dropped request sets it, and the software clear resets it. The bench provokes the collision by starting a single-shot conversion and then, while that conversion is still running, raising a new request together with flag_clr in one cycle. It judges the result at the ports. The flag must read 1 afterwards, the running conversion must still deliver exactly one correct sample, and a later clear on its own must bring the flag back to 0.

// File: rtl/conv_seq_pkg.sv
// Package: shared state type and elaboration helpers for the conversion sequencer.
// Assumes all arguments to the helpers are non-negative integers.
package conv_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_PULSE     = 3'd1,
        S_WAIT_RISE = 3'd2,
        S_WAIT_FALL = 3'd3,
        S_CAPTURE   = 3'd4
    } seq_state_t;

    // Integer division rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // True when a start high time (ns) avoids the forbidden falling-edge interval.
    function automatic bit high_time_legal(input int high_ns, input int period_ns);
        return ((high_ns >= 10)  && (high_ns <= 110)) ||
               ((high_ns >= 160) && (high_ns <= 300)) ||
               ((high_ns > 300)  && (period_ns > 333));
    endfunction

endpackage

// File: rtl/cs_eoc_sync.sv
// Module: cs_eoc_sync
// Brings the asynchronous end-of-conversion level into the clock domain
// through a chain of STAGES flops. Assumes STAGES >= 2 and that the input is
// a level which holds for several clock cycles.
module cs_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // First stage samples the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    // Remaining stages each move the level one flop along.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/cs_pacer.sv
// Module: cs_pacer
// Merges the two request sources. In continuous mode a down-counter raises a
// request once every PERIOD_CYC cycles, starting in the first cycle the pacer
// is enabled. In single-shot mode the request input passes straight through.
// Assumes PERIOD_CYC >= 2.
module cs_pacer #(
    parameter int PERIOD_CYC = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_cont,
    input  logic run_en,
    input  logic single_req,
    output logic req
);
    localparam int CNT_W = $clog2(PERIOD_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD_CYC - 1);

    logic             running;
    logic [CNT_W-1:0] cnt_q;

    assign running = mode_cont & run_en;

    // Period counter: held at zero while stopped, reloads on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!running)        cnt_q <= '0;
        else if (cnt_q == '0)     cnt_q <= RELOAD;
        else                      cnt_q <= cnt_q - 1'b1;
    end

    // Request mux: pacer tick or single-shot request, by mode.
    always_comb begin
        if (mode_cont) req = running && (cnt_q == '0);
        else           req = single_req;
    end

endmodule

// File: rtl/cs_fsm.sv
// Module: cs_fsm
// Runs one conversion: pulse, wait for busy, wait for done, settle, capture.
// A request is accepted only when idle and the synchronised busy level is
// low; any other request is reported as dropped. Both handshake waits are
// bounded by timeouts. Assumes HIGH_CYC, RISE_TO and FALL_TO are >= 1.
module cs_fsm
    import conv_seq_pkg::*;
#(
    parameter int HIGH_CYC = 2,
    parameter int RISE_TO  = 8,
    parameter int FALL_TO  = 48,
    parameter int CAP_DLY  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic eoc_busy,
    output logic start_o,
    output logic cap_en,
    output logic overrun_set,
    output logic timeout_set
);
    localparam int MAXV  = imax(imax(HIGH_CYC, RISE_TO), imax(FALL_TO, CAP_DLY + 1));
    localparam int CNT_W = $clog2(MAXV + 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             start_q, start_d;
    logic             accept;

    assign accept      = req && (state_q == S_IDLE) && !eoc_busy;
    assign overrun_set = req && !accept;
    assign start_o     = start_q;

    // Next-state, counter and pulse decisions for the conversion sequence.
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        start_d     = start_q;
        cap_en      = 1'b0;
        timeout_set = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = S_PULSE;
                    start_d = 1'b1;
                    cnt_d   = CNT_W'(HIGH_CYC - 1);
                end
            end
            S_PULSE: begin
                if (cnt_q == '0) begin
                    start_d = 1'b0;
                    state_d = S_WAIT_RISE;
                    cnt_d   = CNT_W'(RISE_TO - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            S_WAIT_RISE: begin
                if (eoc_busy) begin
                    state_d = S_WAIT_FALL;
                    cnt_d   = CNT_W'(FALL_TO - 1);
                end else if (cnt_q == '0) begin
                    timeout_set = 1'b1;
                    state_d     = S_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            S_WAIT_FALL: begin
                if (!eoc_busy) begin
                    state_d = S_CAPTURE;
                    cnt_d   = CNT_W'(CAP_DLY);
                end else if (cnt_q == '0) begin
                    timeout_set = 1'b1;
                    state_d     = S_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            S_CAPTURE: begin
                if (cnt_q == '0) begin
                    cap_en  = 1'b1;
                    state_d = S_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
                start_d = 1'b0;
            end
        endcase
    end

    // Sequence registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            start_q <= start_d;
        end
    end

    // Checker state: cycles the start pulse has been high so far.
    logic [CNT_W-1:0] hi_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_cnt_q <= '0;
        else if (start_q) hi_cnt_q <= hi_cnt_q + 1'b1;
        else              hi_cnt_q <= '0;
    end

    // R2: the pulse never outlasts its configured width.
    p_width_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (hi_cnt_q < CNT_W'(HIGH_CYC)));

    // R2: the pulse ends exactly when the configured width is reached.
    p_width_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> (hi_cnt_q == CNT_W'(HIGH_CYC)));

    // R5: a start edge never follows a cycle with the converter busy.
    p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> !$past(eoc_busy));

    // R6: a request outside idle never produces a start pulse.
    p_no_start_midseq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (state_q != S_IDLE)) |=> !$rose(start_q));

    // R7: capture only happens with the converter reported done.
    p_cap_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !eoc_busy);

endmodule

// File: rtl/cs_capture.sv
// Module: cs_capture
// Latches the converter's parallel word when told to and raises a one-cycle
// valid strobe. Assumes the word is stable whenever cap_en is high.
module cs_capture #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q
);
    // Result register with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= cap_en;
            if (cap_en) data_q <= data_in;
        end
    end

    // R7: the valid strobe is a single-cycle pulse.
    p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R7: the result register only moves together with a strobe.
    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(data_q) || $past(!rst_n));

endmodule

// File: rtl/cs_flags.sv
// Module: cs_flags
// Keeps the sticky overrun and timeout flags. A set in the same cycle as a
// clear wins. Assumes the set inputs are single-cycle events.
module cs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_set,
    input  logic tmo_set,
    input  logic clr,
    output logic overrun_q,
    output logic timeout_q
);
    // Overrun flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun_q <= 1'b0;
        else if (ovr_set) overrun_q <= 1'b1;
        else if (clr)     overrun_q <= 1'b0;
    end

    // Timeout flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       timeout_q <= 1'b0;
        else if (tmo_set) timeout_q <= 1'b1;
        else if (clr)     timeout_q <= 1'b0;
    end

    // R11: the flag holds without a clear.
    p_overrun_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_q && !clr) |=> overrun_q);

    // R11: a set always lands, even against a clear.
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_set && clr) |=> overrun_q);

    // R9: a timeout event always shows on the error flag.
    p_timeout_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_set |=> timeout_q);

endmodule

// File: rtl/conv_sequencer.sv
// Module: conv_sequencer (top)
// Sequences an external sampling converter: paced or single-shot starts,
// synchronised busy handshake, delayed capture, sticky error flags. At
// elaboration the start width and sample period are forced legal for a
// clock of CLK_NS nanoseconds. Assumes eoc_in is high while converting.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int DATA_W        = 14,
    parameter int CLK_NS        = 10,
    parameter int SAMPLE_PERIOD = 34,
    parameter int START_HIGH    = 2,
    parameter int RISE_TIMEOUT  = 8,
    parameter int FALL_TIMEOUT  = 48,
    parameter int CAPTURE_DELAY = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cont,
    input  logic              run_en,
    input  logic              single_req,
    input  logic              flag_clr,
    input  logic              eoc_in,
    input  logic [DATA_W-1:0] adc_data,
    output logic              start_conv,
    output logic [DATA_W-1:0] sample_data,
    output logic              sample_valid,
    output logic              overrun,
    output logic              timeout_err
);
    // Start width: keep the request if legal, else the shortest legal width.
    localparam int  MIN_HIGH_CYC = imax(1, ceil_div(10, CLK_NS));
    localparam bit  HIGH_OK      = high_time_legal(START_HIGH * CLK_NS, SAMPLE_PERIOD * CLK_NS);
    localparam int  HIGH_CYC     = HIGH_OK ? START_HIGH : MIN_HIGH_CYC;
    // Period: at least the converter's minimum and room for the low time.
    localparam int  MIN_PER_CYC  = imax(ceil_div(333, CLK_NS), HIGH_CYC + ceil_div(30, CLK_NS));
    localparam int  PERIOD_CYC   = imax(SAMPLE_PERIOD, MIN_PER_CYC);
    // The wait for busy also guarantees the low time before a retry.
    localparam int  RISE_CYC     = imax(RISE_TIMEOUT, ceil_div(30, CLK_NS));
    localparam int  FALL_CYC     = imax(FALL_TIMEOUT, 1);
    localparam int  SYNC_N       = imax(SYNC_STAGES, 2);

    logic eoc_busy;
    logic req;
    logic cap_en;
    logic ovr_set;
    logic tmo_set;

    cs_eoc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (eoc_in),
        .sync_out (eoc_busy)
    );

    cs_pacer #(.PERIOD_CYC(PERIOD_CYC)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_cont  (mode_cont),
        .run_en     (run_en),
        .single_req (single_req),
        .req        (req)
    );

    cs_fsm #(
        .HIGH_CYC (HIGH_CYC),
        .RISE_TO  (RISE_CYC),
        .FALL_TO  (FALL_CYC),
        .CAP_DLY  (CAPTURE_DELAY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .eoc_busy    (eoc_busy),
        .start_o     (start_conv),
        .cap_en      (cap_en),
        .overrun_set (ovr_set),
        .timeout_set (tmo_set)
    );

    cs_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .data_in (adc_data),
        .data_q  (sample_data),
        .valid_q (sample_valid)
    );

    cs_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_set   (ovr_set),
        .tmo_set   (tmo_set),
        .clr       (flag_clr),
        .overrun_q (overrun),
        .timeout_q (timeout_err)
    );

    // R1: everything visible is quiet in the cycle after a reset edge.
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!start_conv && !sample_valid && !overrun && !timeout_err));

    // R7: a sample is never strobed while a start pulse is high.
    p_no_valid_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> !start_conv);

endmodule

// File: tb/tb_conv_sequencer.sv
// Directed bench: a converter model reacts to start_conv, and a monitor
// gathers pulse, spacing and sample statistics that each task checks.
module tb_conv_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 14;
    localparam int PER        = 34;
    localparam int HIGH       = 2;
    localparam int CAP        = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_cont = 1'b0;
    logic         run_en = 1'b0;
    logic         single_req = 1'b0;
    logic         flag_clr = 1'b0;
    logic         eoc_in;
    logic [W-1:0] adc_data = '0;
    logic         start_conv;
    logic [W-1:0] sample_data;
    logic         sample_valid;
    logic         overrun;
    logic         timeout_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // converter model controls and record
    logic         m_eoc = 1'b0;
    logic         force_busy = 1'b0;
    bit           m_en = 1'b1;
    int           m_len = 13;
    int           m_seq = 0;
    logic [W-1:0] m_last = '0;
    int           fall_cyc = 0;
    bit           m_prev = 1'b0;

    // monitor statistics
    int           n_starts, n_valid, data_bad, last_width, last_lat;
    int           last_rise, min_int, max_int, hi_run;
    logic [W-1:0] last_data;
    bit           mon_prev = 1'b0;

    assign eoc_in = m_eoc | force_busy;

    conv_sequencer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_cont    (mode_cont),
        .run_en       (run_en),
        .single_req   (single_req),
        .flag_clr     (flag_clr),
        .eoc_in       (eoc_in),
        .adc_data     (adc_data),
        .start_conv   (start_conv),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .overrun      (overrun),
        .timeout_err  (timeout_err)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
    end

    function automatic logic [W-1:0] pattern(input int k);
        if (k % 5 == 1) return 14'h3FFF;
        if (k % 5 == 2) return 14'h0000;
        return W'(k * 1237 + 8192);
    endfunction

    // Converter model: busy from the start edge for m_len cycles, data valid at fall.
    initial forever begin
        @(negedge clk);
        if (m_en && start_conv && !m_prev) begin
            m_eoc    = 1'b1;
            adc_data = 14'h2AAA;
            repeat (m_len) @(negedge clk);
            m_seq    = m_seq + 1;
            adc_data = pattern(m_seq);
            m_last   = adc_data;
            fall_cyc = cyc;
            m_eoc    = 1'b0;
        end
        m_prev = start_conv;
    end

    // Monitor, sampling away from the active edge.
    initial forever begin
        @(negedge clk);
        if (start_conv && !mon_prev) begin
            n_starts = n_starts + 1;
            if (last_rise >= 0) begin
                if (cyc - last_rise < min_int) min_int = cyc - last_rise;
                if (cyc - last_rise > max_int) max_int = cyc - last_rise;
            end
            last_rise = cyc;
            hi_run    = 0;
        end
        if (start_conv) hi_run = hi_run + 1;
        if (!start_conv && mon_prev) last_width = hi_run;
        if (sample_valid) begin
            n_valid   = n_valid + 1;
            last_data = sample_data;
            last_lat  = cyc - fall_cyc;
            if (sample_data !== m_last) data_bad = data_bad + 1;
        end
        mon_prev = start_conv;
    end

    task automatic clear_stats();
        n_starts = 0; n_valid = 0; data_bad = 0; last_width = 0; last_lat = 0;
        last_rise = -1; min_int = 1000000; max_int = 0; hi_run = 0; last_data = '0;
    endtask

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk); single_req = 1'b1;
        @(negedge clk); single_req = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_n(3);
        chk(!start_conv && !sample_valid, "R1", "start/valid in reset", int'(start_conv) + int'(sample_valid), 0);
        chk(!overrun && !timeout_err, "R1", "flags in reset", int'(overrun) + int'(timeout_err), 0);
        chk(sample_data == '0, "R1", "sample_data in reset", int'(sample_data), 0);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_single();
        mode_cont = 1'b0; run_en = 1'b1;
        clear_stats();
        wait_n(40);
        chk(n_starts == 0, "R4", "starts with run_en in single mode", n_starts, 0);
        for (int i = 0; i < 3; i++) begin
            clear_stats();
            pulse_req();
            wait_n(40);
            chk(n_starts == 1, "R4", "starts per request", n_starts, 1);
            chk(last_width == HIGH, "R2", "pulse width", last_width, HIGH);
            chk(n_valid == 1, "R7", "valid pulses", n_valid, 1);
            chk(data_bad == 0 && last_data == m_last, "R7", "captured word", int'(last_data), int'(m_last));
            chk(last_lat == CAP + 4, "R8", "fall-to-valid edges", last_lat, CAP + 4);
        end
        chk(!overrun, "R4", "no overrun in clean single shots", int'(overrun), 0);
        run_en = 1'b0;
    endtask

    task automatic t_continuous();
        clear_stats();
        @(negedge clk); mode_cont = 1'b1; run_en = 1'b1;
        wait_n(PER * 6);
        run_en = 1'b0;
        wait_n(60);
        mode_cont = 1'b0;
        chk(n_starts >= 6, "R3", "paced starts", n_starts, 6);
        chk(min_int == PER && max_int == PER, "R3", "start spacing", max_int, PER);
        chk(n_valid == n_starts && data_bad == 0, "R3", "samples per start", n_valid, n_starts);
        chk(!overrun, "R3", "no overrun at nominal rate", int'(overrun), 0);
    endtask

    task automatic t_busy_block();
        force_busy = 1'b1;
        wait_n(4);
        clear_stats();
        pulse_req();
        wait_n(10);
        chk(n_starts == 0, "R5", "start while busy", n_starts, 0);
        chk(overrun, "R5", "overrun on blocked start", int'(overrun), 1);
        force_busy = 1'b0;
        wait_n(4);
        pulse_clr();
        chk(!overrun, "R11", "overrun after clear", int'(overrun), 0);
    endtask

    task automatic t_req_during_conv();
        clear_stats();
        pulse_req();
        wait_n(6);
        pulse_req();
        wait_n(40);
        chk(n_starts == 1, "R6", "starts with mid-sequence request", n_starts, 1);
        chk(n_valid == 1 && data_bad == 0, "R6", "sample still delivered", n_valid, 1);
        chk(overrun, "R6", "overrun on dropped request", int'(overrun), 1);
        pulse_clr();
    endtask

    task automatic t_rise_timeout();
        m_en = 1'b0;
        clear_stats();
        pulse_req();
        wait_n(20);
        chk(timeout_err, "R9", "timeout without busy", int'(timeout_err), 1);
        chk(n_valid == 0 && n_starts == 1, "R9", "no sample on rise timeout", n_valid, 0);
        m_en = 1'b1;
        pulse_clr();
        chk(!timeout_err, "R11", "timeout after clear", int'(timeout_err), 0);
        clear_stats();
        pulse_req();
        wait_n(40);
        chk(n_valid == 1 && data_bad == 0, "R9", "recovery after timeout", n_valid, 1);
    endtask

    task automatic t_fall_timeout();
        m_len = 100;
        clear_stats();
        pulse_req();
        wait_n(70);
        chk(timeout_err, "R10", "timeout on stuck busy", int'(timeout_err), 1);
        wait_n(60);
        chk(n_valid == 0, "R10", "no sample after late fall", n_valid, 0);
        m_len = 13;
        pulse_clr();
    endtask

    task automatic t_clear_priority();
        clear_stats();
        pulse_req();
        wait_n(5);
        @(negedge clk); single_req = 1'b1; flag_clr = 1'b1;
        @(negedge clk); single_req = 1'b0; flag_clr = 1'b0;
        chk(overrun, "R11", "set wins over clear", int'(overrun), 1);
        wait_n(40);
        chk(n_valid == 1 && data_bad == 0, "R11", "sample during collision", n_valid, 1);
        chk(overrun, "R11", "flag sticky", int'(overrun), 1);
        pulse_clr();
        chk(!overrun, "R11", "lone clear", int'(overrun), 0);
    endtask

    task automatic t_slow_continuous();
        m_len = 40;
        clear_stats();
        @(negedge clk); mode_cont = 1'b1; run_en = 1'b1;
        wait_n(100);
        run_en = 1'b0;
        wait_n(80);
        mode_cont = 1'b0;
        chk(overrun, "R12", "overrun on slow conversion", int'(overrun), 1);
        chk(n_starts == 2, "R12", "starts served", n_starts, 2);
        chk(min_int == 2 * PER, "R12", "start spacing", min_int, 2 * PER);
        chk(n_valid == 2 && data_bad == 0, "R12", "samples delivered", n_valid, 2);
        chk(!timeout_err, "R12", "no timeout", int'(timeout_err), 0);
        m_len = 13;
        pulse_clr();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk = n_chk + 1;
        n_err = n_err + 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        clear_stats();
        t_reset();
        t_single();
        t_continuous();
        t_busy_block();
        t_req_during_conv();
        t_rise_timeout();
        t_fall_timeout();
        t_clear_priority();
        t_slow_continuous();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule